// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives a bus host byte-wide read and write access to a 128-entry register file kept outside the block. The bus pins are sampled with the system clock through a short synchronizer, so the bus clock may have any relation to the system clock as long as the system clock runs at least about eight times faster. SDA is driven as an open-drain line: the block raises an output enable whenever the line must be pulled low and never drives it high.

A write transfer carries the device address, then a pointer byte, then any number of data bytes. The pointer byte's top bit turns on auto-increment and its low seven bits pick a register. Each data byte produces a one-cycle write strobe with the register number and the data. A read transfer returns data from the register chosen by the stored pointer. A read never changes the stored pointer, so the host sets it with a write that it stops right after the pointer byte. The device address is a fixed `0010` prefix followed by three strap inputs, which are captured while reset is held.

Top module: `i2c_regport`

## Requirements
- R1: A stop (SDA rising while SCL is high) sends the block to idle with SDA released at any point, and bus clocks seen in idle without a start get no acknowledge and cause no write.
- R2: After a start, the first byte arrives MSB first as seven address bits and a direction bit (1 read, 0 write). Only address {0010, strap} is acknowledged, by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R3: The strap inputs are sampled while reset is asserted and held after that. Changing them after reset has no effect on the matched address.
- R4: In a write, the byte after the address is the pointer. Bit 7 enables auto-increment and bits 6:0 select the register. Every byte the block receives is acknowledged.
- R5: Every write data byte produces exactly one single-cycle reg_we pulse carrying reg_addr and reg_wdata. With auto-increment off, all data bytes of a transfer go to the pointer's register.
- R6: With auto-increment on, successive data bytes of one transfer use successive registers, and register 127 is followed by register 0.
- R7: A read returns register bytes MSB first, beginning at the stored pointer. A read does not change the stored pointer, so a second read starts at the same register.
- R8: In a read, an acknowledge from the host selects the next byte: the following register with auto-increment, or the same register without it. A not-acknowledge makes the block release SDA and stay silent until a stop or a start.
- R9: A repeated start at any point, including in the middle of a byte, restarts address reception. A pointer written before the repeated start is used by a read that follows it.
- R10: The block only pulls SDA low, and its output enable rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Low three bits of the device address |
| sda_oe | output | 1 | When high, pull SDA low |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_addr | output | 7 | Register number for the write strobe and for read data |
| reg_wdata | output | 8 | Data for the write strobe |
| reg_rdata | input | 8 | Contents of register reg_addr, returned by the register file |

## Verification
The address byte is swept over all 128 values with write direction, so the bench can tell an exact match from matches on the prefix or on the straps alone. A late strap change then shows that the straps are held. Write bursts across the 127-to-0 boundary with auto-increment, and repeated writes without it, distinguish sequential from fixed addressing. Reads with an ack-ack-nack sequence, with both pointer modes, show per-byte stepping, pointer retention across transfers and release after a not-acknowledge. Interrupted transfers cover three cases: a repeated start after the pointer byte, a repeated start in the middle of a data byte, and a wrong address followed by more bytes. Together they separate restart handling from idle handling.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;
  localparam int PTR_W  = BYTE_W - 1;
  localparam int BIT_CW = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } xfer_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;
  localparam int SCL_IX = 1;
  localparam int SDA_IX = 0;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= synced;
  end

  assign scl_s     = synced[SCL_IX];
  assign sda_s     = synced[SDA_IX];
  assign scl_rise  = synced[SCL_IX] & ~prev[SCL_IX];
  assign scl_fall  = ~synced[SCL_IX] & prev[SCL_IX];
  assign start_det = synced[SCL_IX] & prev[SCL_IX] & prev[SDA_IX] & ~synced[SDA_IX];
  assign stop_det  = synced[SCL_IX] & prev[SCL_IX] & ~prev[SDA_IX] & synced[SDA_IX];
endmodule

// File: rtl/i2c_ptr_reg.sv
module i2c_ptr_reg
  import i2c_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_we,
  input  logic [BYTE_W-1:0] ptr_din,
  input  logic              cur_load,
  input  logic              cur_step,
  output logic [PTR_W-1:0]  cursor
);
  logic [PTR_W-1:0] ptr_q;
  logic             auto_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      auto_q <= 1'b0;
      cursor <= '0;
    end else if (ptr_we) begin
      ptr_q  <= ptr_din[PTR_W-1:0];
      auto_q <= ptr_din[BYTE_W-1];
      cursor <= ptr_din[PTR_W-1:0];
    end else if (cur_load) begin
      cursor <= ptr_q;
    end else if (cur_step && auto_q) begin
      cursor <= cursor + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import i2c_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic [BYTE_W-1:0] rdata,
  output logic              ptr_we,
  output logic [BYTE_W-1:0] ptr_din,
  output logic              cur_load,
  output logic              cur_step,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_wdata
);
  xfer_state_t       state;
  logic [BIT_CW-1:0] bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] rx_byte;
  logic              is_read;
  logic              got_ack;
  logic              byte_end;

  assign rx_byte  = {shreg[BYTE_W-2:0], sda_s};
  assign byte_end = (bitcnt == BIT_CW'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    reg_we   <= 1'b0;
    ptr_we   <= 1'b0;
    cur_load <= 1'b0;
    cur_step <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      sda_oe    <= 1'b0;
      is_read   <= 1'b0;
      got_ack   <= 1'b0;
      reg_wdata <= '0;
      ptr_din   <= '0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WR: begin
          if (scl_rise) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 1'b1;
            if (byte_end) begin
              if (state == ST_ADDR) begin
                if (rx_byte[BYTE_W-1:1] == dev_addr) begin
                  state    <= ST_ADDR_ACK;
                  is_read  <= rx_byte[0];
                  cur_load <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                ptr_din <= rx_byte;
                ptr_we  <= 1'b1;
                state   <= ST_PTR_ACK;
              end else begin
                reg_wdata <= rx_byte;
                reg_we    <= 1'b1;
                state     <= ST_WR_ACK;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            if (!sda_oe) begin
              sda_oe <= 1'b1;
            end else begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              if (state == ST_ADDR_ACK) begin
                if (is_read) begin
                  shreg  <= rdata;
                  sda_oe <= ~rdata[BYTE_W-1];
                  state  <= ST_RD;
                end else begin
                  state <= ST_PTR;
                end
              end else begin
                cur_step <= (state == ST_WR_ACK);
                state    <= ST_WR;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (byte_end) begin
              sda_oe  <= 1'b0;
              bitcnt  <= '0;
              got_ack <= 1'b0;
              state   <= ST_RD_ACK;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~shreg[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            if (!sda_s) begin
              got_ack  <= 1'b1;
              cur_step <= 1'b1;
            end else begin
              state <= ST_WAIT;
            end
          end else if (scl_fall && got_ack) begin
            shreg  <= rdata;
            sda_oe <= ~rdata[BYTE_W-1];
            bitcnt <= '0;
            state  <= ST_RD;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W     = 3,
  parameter logic [DEV_W-STRAP_W-1:0] DEV_PREFIX = 'b0010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe,
  output logic               reg_we,
  output logic [PTR_W-1:0]   reg_addr,
  output logic [BYTE_W-1:0]  reg_wdata,
  input  logic [BYTE_W-1:0]  reg_rdata
);
  logic               scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [STRAP_W-1:0] strap_q;
  logic               ptr_we, cur_load, cur_step;
  logic [BYTE_W-1:0]  ptr_din;
  logic [DEV_W-1:0]   dev_addr;

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_i;
  end

  assign dev_addr = {DEV_PREFIX, strap_q};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_xfer_fsm u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .dev_addr(dev_addr), .rdata(reg_rdata),
    .ptr_we(ptr_we), .ptr_din(ptr_din), .cur_load(cur_load), .cur_step(cur_step),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_wdata(reg_wdata)
  );

  i2c_ptr_reg u_ptr (
    .clk(clk), .rst(rst), .ptr_we(ptr_we), .ptr_din(ptr_din),
    .cur_load(cur_load), .cur_step(cur_step), .cursor(reg_addr)
  );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic reg_we
);
  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  // R5
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R4
  we_not_during_ack_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !sda_oe);
endmodule

bind i2c_regport i2c_regport_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .reg_we(reg_we)
);

// File: tb/test_i2c_regport.sv
module test_i2c_regport;
  localparam int Q = 6;
  localparam logic [6:0] DEV = 7'h15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_r = 1'b1;
  logic       host_low = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       sda_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sda_line;

  logic [7:0] mem [128];
  logic [6:0] wl_addr [16];
  logic [7:0] wl_data [16];
  int n_wr = 0;
  int n_chk = 0;
  int n_bad = 0;
  int viol = 0;
  bit done = 0;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  assign sda_line  = ~(sda_oe | host_low);
  assign reg_rdata = mem[reg_addr];

  i2c_regport i_i2c_regport (
    .clk(clk), .rst(rst), .scl_i(scl_r), .sda_i(sda_line), .strap_i(strap),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 11) & 255);

  always @(posedge clk) begin
    if (!rst && reg_we) begin
      mem[reg_addr] = reg_wdata;
      if (n_wr < 16) begin
        wl_addr[n_wr] = reg_addr;
        wl_data[n_wr] = reg_wdata;
      end
      n_wr = n_wr + 1;
    end
  end

  // R10 monitor: output enable must not rise while the bus clock is high
  always @(negedge clk) begin
    if (!rst && sda_oe && !prev_oe && scl_r) viol = viol + 1;
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic drive_low, output logic seen);
    host_low = drive_low;
    tick(Q);
    scl_r = 1'b1;
    tick(Q);
    seen = sda_line;
    tick(Q);
    scl_r = 1'b0;
    tick(Q);
  endtask

  task automatic bus_start();
    host_low = 1'b0;
    tick(Q);
    scl_r = 1'b1;
    tick(Q);
    host_low = 1'b1;
    tick(Q);
    scl_r = 1'b0;
    tick(Q);
  endtask

  task automatic bus_stop();
    host_low = 1'b1;
    tick(Q);
    scl_r = 1'b1;
    tick(Q);
    host_low = 1'b0;
    tick(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(~b[i], s);
    clk_bit(1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b0, s);
      b[i] = s;
    end
    clk_bit(give_ack, s);
    host_low = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(p, a);
    chk_eq("R4 pointer byte ack", a, 1);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    logic s;
    logic [7:0] tail;
    tick(5);
    rst = 1'b0;
    tick(4);
    chk_eq("R10 reset sda_oe", sda_oe, 0);
    chk_eq("R5 reset reg_we", reg_we, 0);

    // R2 address sweep with write direction
    for (int ad = 0; ad < 128; ad++) begin
      bus_start();
      send_byte({7'(ad), 1'b0}, a);
      bus_stop();
      chk_eq("R2 address sweep", a, (ad == 32'(DEV)) ? 1 : 0);
    end
    chk_eq("R2 no write during sweep", n_wr, 0);

    // R3 straps held after reset
    strap = 3'b010;
    bus_start(); send_byte({7'h12, 1'b0}, a); bus_stop();
    chk_eq("R3 new strap not matched", a, 0);
    bus_start(); send_byte({DEV, 1'b0}, a); bus_stop();
    chk_eq("R3 reset strap still matched", a, 1);

    // R6 auto-increment write across 127 -> 0
    n_wr = 0;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'hFE, a);
    chk_eq("R4 auto pointer ack", a, 1);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'(8'hA1 + 8'h11 * k), a);
      chk_eq("R4 data ack", a, 1);
    end
    bus_stop();
    chk_eq("R6 write count", n_wr, 4);
    for (int k = 0; k < 4; k++) begin
      chk_eq("R6 write addr", wl_addr[k], (8'h7E + k) & 8'h7F);
      chk_eq("R5 write data", wl_data[k], 8'hA1 + 8'h11 * k);
    end

    // R5 fixed pointer write
    n_wr = 0;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h05, a);
    for (int k = 1; k <= 3; k++) send_byte(8'(8'h11 * k), a);
    bus_stop();
    chk_eq("R5 fixed write count", n_wr, 3);
    for (int k = 0; k < 3; k++) begin
      chk_eq("R5 fixed write addr", wl_addr[k], 5);
      chk_eq("R5 fixed write data", wl_data[k], 8'h11 * (k + 1));
    end

    // R8 read without auto-increment, ack ack nack
    set_ptr(8'h05);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk_eq("R2 read address ack", a, 1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k < 2, d);
      chk_eq("R8 fixed read data", d, 8'h33);
    end
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b0, s);
      tail[i] = s;
    end
    chk_eq("R8 released after nack", tail, 8'hFF);
    bus_stop();

    // R6/R8 auto-increment read across the wrap
    set_ptr(8'hFF);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b1, d); chk_eq("R8 auto read 0", d, 8'hB2);
    recv_byte(1'b1, d); chk_eq("R6 auto read wrap", d, 8'hC3);
    recv_byte(1'b0, d); chk_eq("R8 auto read 2", d, 8'hD4);
    bus_stop();

    // R7 pointer unchanged by the read
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, d);
    bus_stop();
    chk_eq("R7 second read same start", d, 8'hB2);

    // R9 repeated start after pointer byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk_eq("R9 restart address ack", a, 1);
    recv_byte(1'b0, d);
    bus_stop();
    chk_eq("R9 read after restart", d, 8'hC3);

    // R9 repeated start inside a data byte
    n_wr = 0;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h40, a);
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h41, a);
    send_byte(8'h5A, a);
    bus_stop();
    chk_eq("R9 mid-byte restart write count", n_wr, 1);
    chk_eq("R9 mid-byte restart addr", wl_addr[0], 8'h41);
    chk_eq("R9 mid-byte restart data", wl_data[0], 8'h5A);

    // R2 wrong address: rest of transfer ignored
    n_wr = 0;
    bus_start();
    send_byte({7'h24, 1'b0}, a);
    chk_eq("R2 wrong address nack", a, 0);
    send_byte(8'h02, a);
    chk_eq("R2 ignored byte nack", a, 0);
    send_byte(8'h77, a);
    chk_eq("R2 ignored data nack", a, 0);
    bus_stop();
    chk_eq("R2 ignored no writes", n_wr, 0);

    // R1 stop returns to idle
    bus_start();
    send_byte({DEV, 1'b0}, a);
    bus_stop();
    tick(Q);
    chk_eq("R1 released after stop", sda_oe, 0);
    scl_r = 1'b0;
    tick(Q);
    send_byte(8'h03, a);
    chk_eq("R1 idle no ack", a, 0);
    send_byte(8'h99, a);
    bus_stop();
    chk_eq("R1 idle no writes", n_wr, 0);

    chk_eq("R10 oe rose with scl high", viol, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule